// File: doc/BRIEF.md
# Fractional Cluster Element Mapper

This block converts a vector element index into the byte position that element occupies inside a single vector register when the register is populated sparsely. The register is divided into repeating pairs. Each pair is a lower half of C bytes followed by an upper half of C bytes, where C is the cluster size. A three-bit fill code selects which half of each pair carries data and how much of that half is used. The mapper walks the used region of each pair from its low byte upward, skips the unused bytes and continues in the next pair.

Each request carries the fill code, the cluster size, the element width and the element index. The result appears one clock later together with three flags. The first flag says whether the element lies fully inside the register. The second marks fill codes that are reserved for single-operand accesses. The third marks an illegal cluster configuration. The mask bit that governs an element remains the bit at the element's index, so callers use `req_idx` directly for masking and use this block only for data placement.

Top module: `frac_cluster_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_vld`, `res_off`, `res_inrange`, `res_rsvd` and `res_badcfg` are all cleared to zero.
- R2: A request presented with `req_vld` high at a clock edge produces its result, with `res_vld` high, after exactly that edge. After an edge with `req_vld` low, `res_vld` is low and `res_off` together with the flags keeps its previous value.
- R3: Fill code 3'b000 is fully packed, and the offset equals `req_idx` times E, where E = 2^`req_sew` bytes (encodings 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits).
- R4: Fill codes 3'b001 and 3'b010 use a full C bytes per pair, where C = 2^`req_clog`. With n = C/E elements per cluster, the offset is (idx/n)·2C + (idx mod n)·E. Code 3'b010 adds C, which places the data in the upper half.
- R5: Fill codes 3'b101 and 3'b110 use C/2 bytes per pair, aligned to the low end of the chosen half, with n = C/(2E) in the formula of R4. Code 3'b101 selects the lower half and 3'b110 the upper half, which adds C.
- R6: Fill code 3'b100 uses C/4 bytes per pair, always in the lower half, with n = C/(4E).
- R7: Fill codes 3'b011 and 3'b111 are reserved. They set `res_rsvd`, clear `res_inrange` and report `res_off` = 0.
- R8: A configuration is illegal when C < 4E, which is `req_clog` < `req_sew` + 2, or when 2C exceeds the register length, which is `req_clog` ≥ log2(`VLEN_BYTES`). An illegal configuration sets `res_badcfg`, clears `res_inrange` and reports `res_off` = 0. The two error flags are independent of each other.
- R9: For a legal, non-reserved request, `res_inrange` is 1 exactly when `res_off` + E ≤ `VLEN_BYTES`. The computed offset is reported even when it falls outside the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_fill | input | 3 | Fill code |
| req_clog | input | CLOG_W | log2 of cluster size in bytes |
| req_sew | input | 2 | log2 of element width in bytes |
| req_idx | input | IDX_W | Element index |
| res_vld | output | 1 | Result strobe, one cycle after the request |
| res_off | output | OFF_W | Byte offset in the register |
| res_inrange | output | 1 | Element fits inside the register |
| res_rsvd | output | 1 | Reserved fill code |
| res_badcfg | output | 1 | Illegal cluster and width combination |

## Verification
A wrong half selection or a wrong density shift inside the mapper shows up in `res_off` one cycle after the request that triggers it. It appears as an offset whose cluster-half bit or pair stride is wrong. A decode fault on the reserved codes shows up at the same point as a flag that is missing or spurious, or as a nonzero offset. The sweep covers every fill code, element width, cluster size and index up to 127 on a 64-byte register. Every error therefore appears in the cycle after the first request that triggers it.

// File: rtl/mfc_pkg.sv
// Shared types for the fractional cluster element mapper.
package mfc_pkg;

    // Fill codes; the numeric values are decoded by software-visible state.
    typedef enum logic [2:0] {
        FILL_PACKED      = 3'b000,
        FILL_HALF_LO     = 3'b001,
        FILL_HALF_HI     = 3'b010,
        FILL_RSV_PAIR    = 3'b011,
        FILL_EIGHTH_LO   = 3'b100,
        FILL_QUARTER_LO  = 3'b101,
        FILL_QUARTER_HI  = 3'b110,
        FILL_RSV_DUAL    = 3'b111
    } fill_e;

    // Decoded layout: thin = log2 of density reduction relative to 2C bytes.
    typedef struct packed {
        logic [1:0] thin;
        logic       upper;
        logic       rsvd;
    } layout_t;

endpackage

// File: rtl/mfc_fill_decode.sv
// Decodes a fill code into density, half selection and a reserved flag.
// Assumes: reserved codes map to a packed layout so downstream math is benign.
module mfc_fill_decode
    import mfc_pkg::*;
(
    input  logic [2:0] fill_code,
    output layout_t    lay
);

    // Translate the code into its layout fields.
    always_comb begin
        lay = '{thin: 2'd0, upper: 1'b0, rsvd: 1'b0};
        case (fill_e'(fill_code))
            FILL_PACKED:     lay = '{thin: 2'd0, upper: 1'b0, rsvd: 1'b0};
            FILL_HALF_LO:    lay = '{thin: 2'd1, upper: 1'b0, rsvd: 1'b0};
            FILL_HALF_HI:    lay = '{thin: 2'd1, upper: 1'b1, rsvd: 1'b0};
            FILL_QUARTER_LO: lay = '{thin: 2'd2, upper: 1'b0, rsvd: 1'b0};
            FILL_QUARTER_HI: lay = '{thin: 2'd2, upper: 1'b1, rsvd: 1'b0};
            FILL_EIGHTH_LO:  lay = '{thin: 2'd3, upper: 1'b0, rsvd: 1'b0};
            default:         lay = '{thin: 2'd0, upper: 1'b0, rsvd: 1'b1};
        endcase
    end

endmodule

// File: rtl/mfc_cfg_check.sv
// Flags cluster/width combinations the mapper cannot honour.
// Assumes: cluster and width are given as log2 of their byte sizes.
module mfc_cfg_check #(
    parameter int CLOG_W   = 3,
    parameter int VLEN_LOG = 6
) (
    input  logic [CLOG_W-1:0] clog,
    input  logic [1:0]        sew_log,
    output logic              bad
);

    localparam int EXT_W = CLOG_W + 2;

    logic [EXT_W-1:0] clog_x;
    logic [EXT_W-1:0] floor_x;

    // Cluster must hold four elements and a pair must fit the register.
    always_comb begin
        clog_x  = EXT_W'(clog);
        floor_x = EXT_W'(sew_log) + EXT_W'(2);
        bad     = (clog_x < floor_x) || (clog_x >= EXT_W'(VLEN_LOG));
    end

endmodule

// File: rtl/mfc_offset_calc.sv
// Computes the raw byte offset of an element under a decoded layout.
// Assumes: configuration legality is judged elsewhere; the result is then
// meaningful only for legal, non-reserved requests.
module mfc_offset_calc
    import mfc_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CLOG_W = 3,
    parameter int OFF_W  = 16
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [CLOG_W-1:0] clog,
    input  logic [1:0]        sew_log,
    input  layout_t           lay,
    output logic [OFF_W-1:0]  off_raw
);

    localparam int SH_W = CLOG_W + 2;

    logic [SH_W-1:0]  pair_log;
    logic [SH_W-1:0]  drop_log;
    logic [SH_W-1:0]  per_log;
    logic [OFF_W-1:0] idx_x;
    logic [OFF_W-1:0] pair_no;
    logic [OFF_W-1:0] slot_no;
    logic [OFF_W-1:0] half_base;

    // Elements per used cluster, as a shift: log2(2C) - thin - log2(E).
    always_comb begin
        pair_log = SH_W'(clog) + SH_W'(1);
        drop_log = SH_W'(lay.thin) + SH_W'(sew_log);
        per_log  = (pair_log >= drop_log) ? (pair_log - drop_log) : '0;
    end

    // Split the index into pair number and slot, then rebuild the offset.
    always_comb begin
        idx_x     = OFF_W'(idx);
        pair_no   = idx_x >> per_log;
        slot_no   = idx_x & ~({OFF_W{1'b1}} << per_log);
        half_base = lay.upper ? (OFF_W'(1) << clog) : '0;
        off_raw   = (pair_no << pair_log) + half_base + (slot_no << sew_log);
    end

endmodule

// File: rtl/mfc_range_check.sv
// Decides whether an element lies fully within the register.
// Assumes: VLEN_BYTES is a power of two.
module mfc_range_check #(
    parameter int OFF_W      = 16,
    parameter int VLEN_BYTES = 64
) (
    input  logic [OFF_W-1:0] off_raw,
    input  logic [1:0]       sew_log,
    input  logic             bad,
    input  logic             rsvd,
    output logic             inrange
);

    logic [OFF_W:0] end_byte;

    // End of the element compared with the register length.
    always_comb begin
        end_byte = {1'b0, off_raw} + ((OFF_W + 1)'(1) << sew_log);
        inrange  = !bad && !rsvd && (end_byte <= (OFF_W + 1)'(VLEN_BYTES));
    end

endmodule

// File: rtl/frac_cluster_mapper.sv
// Top of the fractional cluster element mapper: one registered stage that
// maps an element index to its byte offset in a sparsely filled register.
// Assumes: VLEN_BYTES is a power of two; sizes are passed as log2 values.
module frac_cluster_mapper
    import mfc_pkg::*;
#(
    parameter int VLEN_BYTES = 64,
    parameter int IDX_W      = 8,
    parameter int CLOG_W     = 3,
    localparam int VLEN_LOG  = $clog2(VLEN_BYTES),
    localparam int OFF_W     = IDX_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [2:0]        req_fill,
    input  logic [CLOG_W-1:0] req_clog,
    input  logic [1:0]        req_sew,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              res_vld,
    output logic [OFF_W-1:0]  res_off,
    output logic              res_inrange,
    output logic              res_rsvd,
    output logic              res_badcfg
);

    layout_t          lay;
    logic             cfg_bad;
    logic             fits;
    logic [OFF_W-1:0] off_raw;
    logic [OFF_W-1:0] off_nxt;

    mfc_fill_decode u_dec (
        .fill_code (req_fill),
        .lay       (lay)
    );

    mfc_cfg_check #(.CLOG_W(CLOG_W), .VLEN_LOG(VLEN_LOG)) u_cfg (
        .clog    (req_clog),
        .sew_log (req_sew),
        .bad     (cfg_bad)
    );

    mfc_offset_calc #(.IDX_W(IDX_W), .CLOG_W(CLOG_W), .OFF_W(OFF_W)) u_calc (
        .idx     (req_idx),
        .clog    (req_clog),
        .sew_log (req_sew),
        .lay     (lay),
        .off_raw (off_raw)
    );

    mfc_range_check #(.OFF_W(OFF_W), .VLEN_BYTES(VLEN_BYTES)) u_rng (
        .off_raw (off_raw),
        .sew_log (req_sew),
        .bad     (cfg_bad),
        .rsvd    (lay.rsvd),
        .inrange (fits)
    );

    // Suppress the offset for any request that has no legal placement.
    always_comb begin
        off_nxt = (cfg_bad || lay.rsvd) ? '0 : off_raw;
    end

    // Result strobe tracks the request strobe one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) res_vld <= 1'b0;
        else        res_vld <= req_vld;
    end

    // Result fields load on accepted requests and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_off     <= '0;
            res_inrange <= 1'b0;
            res_rsvd    <= 1'b0;
            res_badcfg  <= 1'b0;
        end else if (req_vld) begin
            res_off     <= off_nxt;
            res_inrange <= fits;
            res_rsvd    <= lay.rsvd;
            res_badcfg  <= cfg_bad;
        end
    end

endmodule

// File: rtl/frac_cluster_mapper_chk.sv
// Property checker for the fractional cluster element mapper, bound to the top.
module frac_cluster_mapper_chk #(
    parameter int VLEN_BYTES = 64,
    parameter int IDX_W      = 8,
    parameter int CLOG_W     = 3,
    parameter int OFF_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [2:0]        req_fill,
    input logic [CLOG_W-1:0] req_clog,
    input logic [1:0]        req_sew,
    input logic [IDX_W-1:0]  req_idx,
    input logic              res_vld,
    input logic [OFF_W-1:0]  res_off,
    input logic              res_inrange,
    input logic              res_rsvd,
    input logic              res_badcfg
);

    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R2
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!res_vld && $stable(res_off) && $stable(res_inrange)));

    // R7
    reserved_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_rsvd) |-> (!res_inrange && res_off == '0));

    // R8
    badcfg_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_badcfg) |-> (!res_inrange && res_off == '0));

    // R9
    fits_register_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (!res_inrange ||
            (int'(res_off) + (1 << $past(req_sew)) <= VLEN_BYTES)));

    // R3
    packed_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_fill == 3'b000) |=> (!res_inrange ||
            int'(res_off) == (int'($past(req_idx)) << $past(req_sew))));

    // R4
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (req_fill == 3'b010 || req_fill == 3'b110)) |=>
            (res_badcfg || ((res_off >> $past(req_clog)) & OFF_W'(1)) == OFF_W'(1)));

    // R5
    lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (req_fill == 3'b001 || req_fill == 3'b101 || req_fill == 3'b100)) |=>
            (res_badcfg || ((res_off >> $past(req_clog)) & OFF_W'(1)) == '0));

endmodule

bind frac_cluster_mapper frac_cluster_mapper_chk #(
    .VLEN_BYTES (VLEN_BYTES),
    .IDX_W      (IDX_W),
    .CLOG_W     (CLOG_W),
    .OFF_W      (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_fill    (req_fill),
    .req_clog    (req_clog),
    .req_sew     (req_sew),
    .req_idx     (req_idx),
    .res_vld     (res_vld),
    .res_off     (res_off),
    .res_inrange (res_inrange),
    .res_rsvd    (res_rsvd),
    .res_badcfg  (res_badcfg)
);

// File: tb/sim_frac_cluster_mapper.sv
// Sweep bench: every fill code, width, cluster size and indices 0..127.
module sim_frac_cluster_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int VLENB      = 64;
    localparam int IDXW       = 8;
    localparam int CLW        = 3;
    localparam int OFFW       = IDXW + 8;
    localparam int WATCHDOG   = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0;
    logic [2:0]      req_fill = '0;
    logic [CLW-1:0]  req_clog = '0;
    logic [1:0]      req_sew = '0;
    logic [IDXW-1:0] req_idx = '0;
    logic            res_vld;
    logic [OFFW-1:0] res_off;
    logic            res_inrange;
    logic            res_rsvd;
    logic            res_badcfg;

    int  checks = 0;
    int  errors = 0;
    bit  reported = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frac_cluster_mapper #(.VLEN_BYTES(VLENB), .IDX_W(IDXW), .CLOG_W(CLW)) u0 (
        .clk, .rst_n, .req_vld, .req_fill, .req_clog, .req_sew, .req_idx,
        .res_vld, .res_off, .res_inrange, .res_rsvd, .res_badcfg
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reference placement computed with plain integer division.
    task automatic model(input int f, input int cl, input int s, input int i,
                         output int off, output int inr, output int rsv, output int bad);
        int c, e, used, upper, n;
        c   = 1 << cl;
        e   = 1 << s;
        rsv = (f == 3 || f == 7) ? 1 : 0;
        bad = (cl < s + 2 || cl >= 6) ? 1 : 0;
        case (f)
            0:       begin used = 2 * c; upper = 0; end
            1:       begin used = c;     upper = 0; end
            2:       begin used = c;     upper = c; end
            5:       begin used = c / 2; upper = 0; end
            6:       begin used = c / 2; upper = c; end
            4:       begin used = c / 4; upper = 0; end
            default: begin used = 2 * c; upper = 0; end
        endcase
        if (rsv == 1 || bad == 1) begin
            off = 0;
            inr = 0;
        end else begin
            n   = used / e;
            off = (i / n) * 2 * c + upper + (i % n) * e;
            inr = (off + e <= VLENB) ? 1 : 0;
        end
    endtask

    function automatic string tag_for(input int f, input int bad);
        if (bad != 0)          return "R8";
        if (f == 0)            return "R3";
        if (f == 1 || f == 2)  return "R4";
        if (f == 5 || f == 6)  return "R5";
        if (f == 4)            return "R6";
        return "R7";
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        int eo, ei, er, eb;
        int last_off;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "res_vld", int'(res_vld), 0);
        check("R1", "res_off", int'(res_off), 0);
        check("R1", "res_inrange", int'(res_inrange), 0);
        check("R1", "res_rsvd", int'(res_rsvd), 0);
        check("R1", "res_badcfg", int'(res_badcfg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "idle res_vld", int'(res_vld), 0);

        for (int s = 0; s < 4; s++) begin
            for (int cl = 0; cl < 8; cl++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int i = 0; i < 128; i++) begin
                        req_vld  = 1'b1;
                        req_fill = 3'(f);
                        req_clog = CLW'(cl);
                        req_sew  = 2'(s);
                        req_idx  = IDXW'(i);
                        @(negedge clk);
                        model(f, cl, s, i, eo, ei, er, eb);
                        check("R2", "res_vld", int'(res_vld), 1);
                        check(tag_for(f, eb), "res_off", int'(res_off), eo);
                        check("R9", "res_inrange", int'(res_inrange), ei);
                        check("R7", "res_rsvd", int'(res_rsvd), er);
                        check("R8", "res_badcfg", int'(res_badcfg), eb);
                    end
                end
            end
        end

        // R2: no request leaves result fields unchanged
        last_off = int'(res_off);
        req_vld  = 1'b0;
        req_fill = 3'b010;
        req_idx  = IDXW'(3);
        @(negedge clk);
        check("R2", "res_vld after idle", int'(res_vld), 0);
        check("R2", "res_off held", int'(res_off), last_off);
        finish_run();
    end

endmodule